// File: doc/BRIEF.md
# Prime Table Display Sequencer

This block cycles through a fixed table of the first 32 prime numbers and shows each value on three seven-segment digits. It runs from a single fast system clock, nominally 50 MHz. A free-running divider counter gives a slow step rate, and each step moves a 5-bit table index on by one.

Each table word is 12 bits wide. It holds the prime as a plain binary value, so it reads as three hexadecimal characters: 131 is stored as 0x083. The word is split into three 4-bit nibbles. Each nibble drives its own hex-to-seven-segment decoder, and the most significant nibble drives the leftmost digit. The segment outputs are registered so that they do not glitch.

Two debug outputs are brought out: the one-cycle step pulse and the current table index. A bench built with a short divider can use them to follow the sequence directly.

Top module: `prime_display_seq`

## Requirements
- R1: Table index k (0..31) holds the k-th prime as an unsigned binary value in 12 bits, from 0x002 at index 0 up to 0x083 (131) at index 31.
- R2: `step_o` is high for exactly one clock cycle at each rising edge of the divider counter's top bit. With a DIV_BITS-bit divider, the first pulse comes 2^(DIV_BITS-1) clocks after reset is released, and later pulses come every 2^DIV_BITS clocks.
- R3: `addr_o` increases by one on the clock edge that follows each step pulse and holds its value at all other times.
- R4: After index 31, the next step wraps `addr_o` to 0.
- R5: Word bits [11:8] drive `seg_o[20:14]` (left digit), bits [7:4] drive `seg_o[13:7]` (middle digit) and bits [3:0] drive `seg_o[6:0]` (right digit).
- R6: Each digit is active-high, with bit 0 = segment a through bit 6 = segment g. The codes for hex values 0..F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R7: The segment outputs are registered: `seg_o` shows the decoded word for the index held one clock earlier.
- R8: A synchronous reset clears the divider, the index and the segment register. While reset is held, `addr_o` is 0, `step_o` is 0 and `seg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (nominally 50 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| step_o | output | 1 | One-cycle pulse at each table step |
| addr_o | output | 5 | Current table index |
| seg_o | output | 21 | Three 7-segment digits, left digit in the top bits |

## Verification
The bench builds the block with a 4-bit divider, so a step comes every 16 clocks.

It targets four corner cases:
- **First step.** The first step must come half a period after reset is released. An off-by-one in the edge detect would move every later index by one cycle.
- **Wrap.** The index must wrap from 31 back to 0. A counter that saturates at 31 would keep showing 0x083.
- **Register delay.** `seg_o` must lag `addr_o` by exactly one register. A combinational path or a doubled register would show each word one cycle early or late.
- **Reset in mid-sequence.** Reset is asserted at random points in the sequence. A divider that is not cleared would produce its next step at a phase that no longer matches the restart.

// File: rtl/prime_disp_pkg.sv
package prime_disp_pkg;

   localparam int unsigned SEG_W = 7;

   // trial division, evaluated at elaboration only
   function automatic bit is_prime(input int unsigned n);
      if (n < 2) return 1'b0;
      for (int unsigned d = 2; d * d <= n; d++) begin
         if (n % d == 0) return 1'b0;
      end
      return 1'b1;
   endfunction

   // k-th prime, k counted from zero
   function automatic int unsigned nth_prime(input int unsigned k);
      int unsigned found;
      int unsigned cand;
      found = 0;
      cand  = 1;
      while (found <= k) begin
         cand++;
         if (is_prime(cand)) found++;
      end
      return cand;
   endfunction

endpackage

// File: rtl/step_divider.sv
module step_divider #(
   parameter int unsigned DIV_BITS = 25
) (
   input  logic clk,
   input  logic rst,
   output logic step_o
);
   localparam int unsigned TOP = DIV_BITS - 1;

   if (DIV_BITS < 2) begin : g_bad_div
      $error("step_divider: DIV_BITS must be at least 2");
   end

   logic [DIV_BITS-1:0] div_q;
   logic                top_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q <= '0;
         top_d <= 1'b0;
      end else begin
         div_q <= div_q + 1'b1;
         top_d <= div_q[TOP];
      end
   end

   assign step_o = div_q[TOP] & ~top_d;

   AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
      step_o |=> !step_o); // R2

endmodule

// File: rtl/addr_counter.sv
module addr_counter #(
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o
);
   if (ADDR_W < 1) begin : g_bad_addr
      $error("addr_counter: ADDR_W must be positive");
   end

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (rst)         addr_q <= '0;
      else if (step_i) addr_q <= addr_q + 1'b1;
   end

   assign addr_o = addr_q;

   AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      step_i |=> addr_q == ADDR_W'($past(addr_q) + 1'b1)); // R3
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(addr_q)); // R3
   AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
      (step_i && (&addr_q)) |=> addr_q == '0); // R4

endmodule

// File: rtl/prime_rom.sv
module prime_rom
   import prime_disp_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [WORD_W-1:0] word_o
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (ADDR_W > 8) begin : g_bad_depth
      $error("prime_rom: table deeper than 256 entries not supported");
   end

   logic [WORD_W-1:0] tbl [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      localparam int unsigned PVAL = nth_prime(i);
      if (PVAL >= (64'd1 << WORD_W)) begin : g_too_narrow
         $error("prime_rom: WORD_W too narrow for table contents");
      end
      assign tbl[i] = WORD_W'(PVAL);
   end

   assign word_o = tbl[addr_i];

   // every prime other than 2 is odd
   AST_ROM_ODD: assert property (@(posedge clk) disable iff (rst)
      word_o[0] || (word_o == WORD_W'(2))); // R1
   AST_ROM_FIRST: assert property (@(posedge clk) disable iff (rst)
      (addr_i == '0) |-> (word_o == WORD_W'(2))); // R1

endmodule

// File: rtl/seg7_hex_dec.sv
module seg7_hex_dec #(
   parameter int unsigned NIB_W = 4,
   parameter int unsigned SEG_W = 7
) (
   input  logic [NIB_W-1:0] nib_i,
   output logic [SEG_W-1:0] seg_o
);
   if (NIB_W != 4 || SEG_W != 7) begin : g_bad_dec
      $error("seg7_hex_dec: only 4-bit nibbles onto 7 segments are supported");
   end

   // bit 0 = a ... bit 6 = g, active-high
   always_comb begin
      unique case (nib_i)
         4'h0: seg_o = 7'h3F;
         4'h1: seg_o = 7'h06;
         4'h2: seg_o = 7'h5B;
         4'h3: seg_o = 7'h4F;
         4'h4: seg_o = 7'h66;
         4'h5: seg_o = 7'h6D;
         4'h6: seg_o = 7'h7D;
         4'h7: seg_o = 7'h07;
         4'h8: seg_o = 7'h7F;
         4'h9: seg_o = 7'h6F;
         4'hA: seg_o = 7'h77;
         4'hB: seg_o = 7'h7C;
         4'hC: seg_o = 7'h39;
         4'hD: seg_o = 7'h5E;
         4'hE: seg_o = 7'h79;
         default: seg_o = 7'h71;
      endcase
   end

   always_comb begin
      AST_SEG_LIT: assert (seg_o != '0); // R6
   end

endmodule

// File: rtl/prime_display_seq.sv
module prime_display_seq
   import prime_disp_pkg::*;
#(
   parameter int unsigned DIV_BITS       = 25,
   parameter int unsigned ADDR_W         = 5,
   parameter int unsigned WORD_W         = 12,
   parameter int unsigned NIB_W          = 4,
   parameter bit          SEG_REGISTERED = 1'b1,
   parameter bit          SEG_ACTIVE_LOW = 1'b0
) (
   input  logic                                  clk,
   input  logic                                  rst,
   output logic                                  step_o,
   output logic [ADDR_W-1:0]                     addr_o,
   output logic [(WORD_W/NIB_W)*SEG_W-1:0]       seg_o
);
   localparam int unsigned DIGITS = WORD_W / NIB_W;
   localparam int unsigned OUT_W  = DIGITS * SEG_W;
   localparam logic [OUT_W-1:0] SEG_OFF = SEG_ACTIVE_LOW ? '1 : '0;

   if (WORD_W % NIB_W != 0) begin : g_bad_split
      $error("prime_display_seq: WORD_W must be a multiple of NIB_W");
   end

   logic              step;
   logic [ADDR_W-1:0] addr;
   logic [WORD_W-1:0] word;
   logic [OUT_W-1:0]  seg_raw;
   logic [OUT_W-1:0]  seg_pol;

   step_divider #(.DIV_BITS(DIV_BITS)) u_div (
      .clk   (clk),
      .rst   (rst),
      .step_o(step)
   );

   addr_counter #(.ADDR_W(ADDR_W)) u_addr (
      .clk   (clk),
      .rst   (rst),
      .step_i(step),
      .addr_o(addr)
   );

   prime_rom #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rom (
      .clk   (clk),
      .rst   (rst),
      .addr_i(addr),
      .word_o(word)
   );

   // nibble d feeds digit d; the top nibble lands in the top (left) field
   for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      seg7_hex_dec #(.NIB_W(NIB_W), .SEG_W(SEG_W)) u_dec (
         .nib_i(word[d*NIB_W +: NIB_W]),
         .seg_o(seg_raw[d*SEG_W +: SEG_W])
      );
   end

   if (SEG_ACTIVE_LOW) begin : g_pol_low
      assign seg_pol = ~seg_raw;
   end else begin : g_pol_high
      assign seg_pol = seg_raw;
   end

   if (SEG_REGISTERED) begin : g_seg_reg
      logic [OUT_W-1:0] seg_q;
      always_ff @(posedge clk) begin
         if (rst) seg_q <= SEG_OFF;
         else     seg_q <= seg_pol;
      end
      assign seg_o = seg_q;

      AST_SEG_RESET: assert property (@(posedge clk)
         rst |=> seg_q == SEG_OFF); // R8
   end else begin : g_seg_comb
      assign seg_o = seg_pol;
   end

   assign step_o = step;
   assign addr_o = addr;

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (addr_o == '0) && !step_o); // R8

endmodule

// File: tb/prime_display_seq_tb.sv
module prime_display_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DIVB       = 4;
   localparam int PER        = 1 << DIVB;
   localparam int HALF       = PER / 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        step_o;
   logic [4:0]  addr_o;
   logic [20:0] seg_o;

   int vectors = 0;
   int fails   = 0;
   int n       = 0;
   int rst_negs = 0;
   bit done    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prime_display_seq #(.DIV_BITS(DIVB)) u_dut (
      .clk   (clk),
      .rst   (rst),
      .step_o(step_o),
      .addr_o(addr_o),
      .seg_o (seg_o)
   );

   function automatic int ref_prime(input int k);
      int found = 0;
      int cand  = 1;
      while (found <= k) begin
         bit p;
         cand++;
         p = 1'b1;
         for (int d = 2; d * d <= cand; d++) if (cand % d == 0) p = 1'b0;
         if (p) found++;
      end
      return cand;
   endfunction

   function automatic logic [6:0] ref_seg(input logic [3:0] v);
      logic [6:0] t [16] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,
                             7'h7F,7'h6F,7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71};
      return t[v];
   endfunction

   function automatic logic [20:0] ref_word_seg(input int k);
      logic [11:0] w;
      w = 12'(ref_prime(k));
      return {ref_seg(w[11:8]), ref_seg(w[7:4]), ref_seg(w[3:0])};
   endfunction

   function automatic int ref_addr(input int cyc);
      return ((cyc + PER - 1 - HALF) / PER) % 32;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s cycle %0d actual %0h expected %0h", req, n, act, exp);
      end
   endtask

   // checker: samples at the falling edge
   always @(negedge clk) begin
      if (!done) begin
         if (rst) begin
            if (rst_negs >= 1) begin
               check("R8 addr in reset", 32'(addr_o), 32'd0);
               check("R8 step in reset", 32'(step_o), 32'd0);
               check("R8 seg in reset",  32'(seg_o),  32'd0);
            end
            rst_negs++;
            n = 0;
         end else begin
            rst_negs = 0;
            // R2: pulse position; R3/R4: index sequence and wrap
            check("R2 step", 32'(step_o), 32'((n >= HALF) && (n % PER == HALF)));
            check("R3/R4 addr", 32'(addr_o), 32'(ref_addr(n)));
            // R1/R5/R6/R7: decoded word for index one cycle earlier
            if (n == 0) check("R7 seg first", 32'(seg_o), 32'd0);
            else        check("R1 R5 R6 R7 seg", 32'(seg_o), 32'(ref_word_seg(ref_addr(n-1))));
            n++;
         end
      end
   end

   task automatic drive_rst(input bit v, input int cycles);
      @(posedge clk);
      #2 rst = v;
      repeat (cycles - 1) @(posedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (2) @(posedge clk);
      // directed: long run covering two wraps (R4)
      drive_rst(1'b0, 2 * 32 * PER + 40);
      // directed: reset right at a step, then restart
      drive_rst(1'b1, 3);
      drive_rst(1'b0, HALF + 1);
      // random resets at random points
      for (int i = 0; i < 8; i++) begin
         drive_rst(1'b1, 1 + int'($urandom % 4));
         drive_rst(1'b0, 20 + int'($urandom % 700));
      end
      drive_rst(1'b1, 3);
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired at cycle %0d", n);
         finish_run();
      end
   end

endmodule